// File: doc/BRIEF.md
# Destination Address Generator with Circular Repeat Window

This block holds and advances the destination address of one DMA channel. A transfer sequencer pulses a step strobe after each transfer. The address then moves up, moves down or stays put, by 1, 2 or 4 bytes. A repeat window can be selected. Its size is a power of two. When a window is active, only the address bits inside the window change and the bits above it stay fixed, so the channel writes round a circular buffer.

When the address leaves the window, the low bits go back to the window's first byte on the way up, or to its last byte on the way down. If the wrap interrupt is enabled, the wrap also stops the channel and sets a sticky status flag. In block mode that stop is held in a pending bit until the sequencer reports the end of the current block. Software controls the block through three word registers: the current address, the mode with the channel enable, and the window. Read data comes back one clock after the select is presented.

Top module: `dma_dst_addr_gen`

## Requirements
- R1: After a synchronous reset, the address, every control field, the channel enable, the status flag, the pending bit, the read data and the interrupt output are all 0.
- R2: A step strobe while the channel is enabled moves the address by the step size. Mode bits [1:0] choose the direction (1 up, 2 down, 0 or 3 hold). Mode bits [3:2] choose the size (0 gives 1 byte, 1 gives 2 bytes, 2 or 3 give 4 bytes). A step strobe while the channel is disabled, or in the same cycle as a write to the address register (select 0), leaves the address unchanged. The write wins.
- R3: The window field is bits [4:0] of the window register (select 2). A value n from 1 to 26 gives a window of 2^(n+1) bytes. A step then changes only address bits [n:0].
- R4: An up step that carries out of the window sets the in-window bits to 0. A down step that borrows out of the window sets them all to 1.
- R5: With a window value of 0 or above 26, the address steps modulo 2^32 and no wrap is ever flagged, even when the wrap interrupt enable is set.
- R6: With the wrap interrupt enable (window register bit 7) set and block mode off, a wrapping step clears the channel enable and sets the status flag on the same clock edge that updates the address.
- R7: With block mode (mode bit 4) set, a wrap that asks for a stop sets a pending bit and the channel keeps running. On the next block-end strobe, or at once if the block ends in the wrap cycle, the enable is cleared, the flag is set and the pending bit is cleared.
- R8: When software sets the enable (mode bit 8) again after a stop, stepping carries on from the current address with no reload.
- R9: The status flag (mode bit 9) stays set until a mode write with bit 9 at 0. A write with bit 9 at 1 leaves the flag unchanged. A hardware stop has priority over a software write in the same cycle. The interrupt output equals the flag AND the wrap interrupt enable.
- R10: Bits 6:5 of the window register always read 0, and writes to them are ignored.
- R11: Read data is registered. It shows the register picked by the select, as it stood just before the clock edge. Select 3 reads 0.
- R12: With the wrap interrupt enable clear, a wrap still folds the address but leaves the enable and the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 mode, 2 window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| xfer_step | input | 1 | One transfer completed; advance the address |
| blk_end | input | 1 | Current block finished |
| dst_addr | output | 32 | Current destination address |
| chan_en | output | 1 | Channel enable |
| wrap_flag | output | 1 | Sticky wrap status flag |
| irq | output | 1 | Wrap interrupt request |

## Verification
Stepping is tried without a window, where the address must roll over the full 32 bits with no flag, and with small and large windows, where an unchanged upper field shows the fold is masked and not a compare. Up and down steps of 1, 2 and 4 bytes from offsets next to the window edge tell carry apart from borrow. They also check that the fold lands on the first or the last byte. Wraps with the interrupt disabled, enabled in direct mode, and enabled in block mode show when the stop happens: never, at once, or on the block-end strobe. A wrap in the same cycle as a block end covers the coincident case. Register writes mixed with strobes check write priority, flag clearing and the reserved bits.

// File: rtl/dag_pkg.sv
package dag_pkg;

  typedef enum logic [1:0] {
    DIR_HOLD     = 2'd0,
    DIR_UP       = 2'd1,
    DIR_DOWN     = 2'd2,
    DIR_HOLD_ALT = 2'd3
  } dag_dir_e;

  // register selects
  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_MODE = 2'd1;
  localparam logic [1:0] SEL_AREA = 2'd2;

  // bit positions in the mode word
  localparam int MODE_DIR_LSB  = 0;
  localparam int MODE_SIZE_LSB = 2;
  localparam int MODE_BLK_BIT  = 4;
  localparam int MODE_EN_BIT   = 8;
  localparam int MODE_FLAG_BIT = 9;

  // bit position of the wrap interrupt enable in the window word
  localparam int AREA_IE_BIT = 7;

  typedef struct packed {
    logic     wrap_ie;
    logic     blk;
    logic [1:0] size;
    dag_dir_e dir;
  } dag_cfg_t;

endpackage

// File: rtl/dag_cfg.sv
module dag_cfg
  import dag_pkg::*;
#(
  parameter int AREA_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic              area_wr,
  input  logic [1:0]        wr_dir,
  input  logic [1:0]        wr_size,
  input  logic              wr_blk,
  input  logic              wr_ie,
  input  logic [AREA_W-1:0] wr_area,
  output dag_cfg_t          cfg_q,
  output logic [AREA_W-1:0] area_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      area_q <= '0;
    end else begin
      if (mode_wr) begin
        cfg_q.dir  <= dag_dir_e'(wr_dir);
        cfg_q.size <= wr_size;
        cfg_q.blk  <= wr_blk;
      end
      if (area_wr) begin
        cfg_q.wrap_ie <= wr_ie;
        area_q        <= wr_area;
      end
    end
  end

endmodule

// File: rtl/dag_addr_step.sv
module dag_addr_step
  import dag_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int AREA_W   = 5,
  parameter int AREA_MAX = 26
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [AREA_W-1:0] area,
  input  dag_dir_e          dir,
  input  logic [1:0]        size,
  output logic [ADDR_W-1:0] nxt,
  output logic              wrap,
  output logic              area_on
);

  localparam int EXT_W = ADDR_W + 1;

  logic [ADDR_W-1:0] mask;
  logic [EXT_W-1:0]  ext_mask;
  logic [EXT_W-1:0]  inc;
  logic [EXT_W-1:0]  lo;
  logic [EXT_W-1:0]  sum;
  logic [EXT_W-1:0]  diff;
  logic              up_wrap;
  logic              dn_wrap;
  logic [ADDR_W-1:0] new_lo;

  assign area_on = (area != '0) && (int'(area) <= AREA_MAX);

  // window mask: bit g is inside the window when g <= area
  for (genvar g = 0; g < ADDR_W; g++) begin : g_mask
    assign mask[g] = !area_on || (g <= int'(area));
  end

  assign ext_mask = {1'b0, mask};

  always_comb begin
    case (size)
      2'd0:    inc = EXT_W'(1);
      2'd1:    inc = EXT_W'(2);
      default: inc = EXT_W'(4);
    endcase
  end

  assign lo   = {1'b0, addr & mask};
  assign sum  = lo + inc;
  assign diff = lo - inc;

  // carry out of the masked field or borrow out of it
  assign up_wrap = area_on && (|(sum & ~ext_mask));
  assign dn_wrap = area_on && diff[ADDR_W];

  always_comb begin
    new_lo = addr & mask;
    wrap   = 1'b0;
    case (dir)
      DIR_UP: begin
        new_lo = up_wrap ? '0 : (sum[ADDR_W-1:0] & mask);
        wrap   = up_wrap;
      end
      DIR_DOWN: begin
        new_lo = dn_wrap ? mask : (diff[ADDR_W-1:0] & mask);
        wrap   = dn_wrap;
      end
      default: ;
    endcase
  end

  assign nxt = (addr & ~mask) | new_lo;

endmodule

// File: rtl/dag_chan_ctrl.sv
module dag_chan_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic mode_wr,
  input  logic wr_en_bit,
  input  logic wr_flag_bit,
  input  logic wrap_arm,
  input  logic blk_mode,
  input  logic blk_end,
  output logic en_q,
  output logic flag_q,
  output logic pend_q
);

  logic hw_stop;

  // direct stop on a wrap, or a deferred stop at block end
  assign hw_stop = (wrap_arm && (!blk_mode || blk_end)) || (blk_end && pend_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (hw_stop)      en_q <= 1'b0;
      else if (mode_wr) en_q <= wr_en_bit;

      if (hw_stop)                      flag_q <= 1'b1;
      else if (mode_wr && !wr_flag_bit) flag_q <= 1'b0;

      if (blk_end)                    pend_q <= 1'b0;
      else if (wrap_arm && blk_mode)  pend_q <= 1'b1;
    end
  end

endmodule

// File: rtl/dma_dst_addr_gen.sv
module dma_dst_addr_gen
  import dag_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int AREA_W   = 5,
  parameter int AREA_MAX = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              xfer_step,
  input  logic              blk_end,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              chan_en,
  output logic              wrap_flag,
  output logic              irq
);

  dag_cfg_t          cfg_q;
  logic [AREA_W-1:0] area_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_nxt;
  logic              wrap;
  logic              area_on;
  logic              en_q;
  logic              flag_q;
  logic              pend_q;
  logic              addr_wr;
  logic              mode_wr;
  logic              area_wr;
  logic              step_fire;
  logic              wrap_arm;
  logic              blk_mode_w;
  logic [ADDR_W-1:0] mode_view;
  logic [ADDR_W-1:0] area_view;

  assign addr_wr = reg_wr_en && (reg_sel == SEL_ADDR);
  assign mode_wr = reg_wr_en && (reg_sel == SEL_MODE);
  assign area_wr = reg_wr_en && (reg_sel == SEL_AREA);

  dag_cfg #(.AREA_W(AREA_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .mode_wr (mode_wr),
    .area_wr (area_wr),
    .wr_dir  (reg_wdata[MODE_DIR_LSB +: 2]),
    .wr_size (reg_wdata[MODE_SIZE_LSB +: 2]),
    .wr_blk  (reg_wdata[MODE_BLK_BIT]),
    .wr_ie   (reg_wdata[AREA_IE_BIT]),
    .wr_area (reg_wdata[AREA_W-1:0]),
    .cfg_q   (cfg_q),
    .area_q  (area_q)
  );

  dag_addr_step #(.ADDR_W(ADDR_W), .AREA_W(AREA_W), .AREA_MAX(AREA_MAX)) u_step (
    .addr    (addr_q),
    .area    (area_q),
    .dir     (cfg_q.dir),
    .size    (cfg_q.size),
    .nxt     (addr_nxt),
    .wrap    (wrap),
    .area_on (area_on)
  );

  assign step_fire  = xfer_step && en_q && !addr_wr;
  assign wrap_arm   = step_fire && wrap && area_on && cfg_q.wrap_ie;
  assign blk_mode_w = cfg_q.blk;

  dag_chan_ctrl u_chan (
    .clk         (clk),
    .rst         (rst),
    .mode_wr     (mode_wr),
    .wr_en_bit   (reg_wdata[MODE_EN_BIT]),
    .wr_flag_bit (reg_wdata[MODE_FLAG_BIT]),
    .wrap_arm    (wrap_arm),
    .blk_mode    (blk_mode_w),
    .blk_end     (blk_end),
    .en_q        (en_q),
    .flag_q      (flag_q),
    .pend_q      (pend_q)
  );

  always_ff @(posedge clk) begin
    if (rst)            addr_q <= '0;
    else if (addr_wr)   addr_q <= reg_wdata;
    else if (step_fire) addr_q <= addr_nxt;
  end

  always_comb begin
    mode_view = '0;
    mode_view[MODE_DIR_LSB +: 2]  = cfg_q.dir;
    mode_view[MODE_SIZE_LSB +: 2] = cfg_q.size;
    mode_view[MODE_BLK_BIT]       = cfg_q.blk;
    mode_view[MODE_EN_BIT]        = en_q;
    mode_view[MODE_FLAG_BIT]      = flag_q;
    area_view = '0;
    area_view[AREA_W-1:0]         = area_q;
    area_view[AREA_IE_BIT]        = cfg_q.wrap_ie;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_sel)
        SEL_ADDR: reg_rdata <= addr_q;
        SEL_MODE: reg_rdata <= mode_view;
        SEL_AREA: reg_rdata <= area_view;
        default:  reg_rdata <= '0;
      endcase
    end
  end

  assign dst_addr  = addr_q;
  assign chan_en   = en_q;
  assign wrap_flag = flag_q;
  assign irq       = flag_q && cfg_q.wrap_ie;

endmodule

// File: rtl/dag_chk.sv
module dag_chk #(
  parameter int ADDR_W   = 32,
  parameter int AREA_W   = 5,
  parameter int AREA_MAX = 26
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr_en,
  input logic [1:0]        reg_sel,
  input logic              flag_wbit,
  input logic [1:0]        rd_resv,
  input logic              xfer_step,
  input logic              blk_end,
  input logic [ADDR_W-1:0] dst_addr,
  input logic              chan_en,
  input logic              wrap_flag,
  input logic              blk_mode,
  input logic [AREA_W-1:0] area
);

  logic [ADDR_W-1:0] win;
  logic              win_on;
  logic              wr_addr;
  logic              wr_mode;

  assign win_on  = (area != '0) && (int'(area) <= AREA_MAX);
  assign wr_addr = reg_wr_en && (reg_sel == 2'd0);
  assign wr_mode = reg_wr_en && (reg_sel == 2'd1);

  always_comb begin
    for (int i = 0; i < ADDR_W; i++) win[i] = (i <= int'(area));
  end

  // R2
  off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!chan_en && !wr_addr) |=> $stable(dst_addr));

  // R3
  area_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_step && chan_en && win_on && !wr_addr)
      |=> (((dst_addr ^ $past(dst_addr)) & ~$past(win)) == '0));

  // R6
  stop_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wrap_flag) |-> !chan_en);

  // R7
  blk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (chan_en && blk_mode && !blk_end && !wr_mode) |=> chan_en);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap_flag && !(wr_mode && !flag_wbit)) |=> wrap_flag);

  // R10
  resv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_sel) == 2'd2) |-> (rd_resv == 2'b00));

endmodule

bind dma_dst_addr_gen dag_chk #(.ADDR_W(ADDR_W), .AREA_W(AREA_W), .AREA_MAX(AREA_MAX)) u_dag_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr_en (reg_wr_en),
  .reg_sel   (reg_sel),
  .flag_wbit (reg_wdata[9]),
  .rd_resv   (reg_rdata[6:5]),
  .xfer_step (xfer_step),
  .blk_end   (blk_end),
  .dst_addr  (dst_addr),
  .chan_en   (chan_en),
  .wrap_flag (wrap_flag),
  .blk_mode  (blk_mode_w),
  .area      (area_q)
);

// File: tb/test_dma_dst_addr_gen.sv
module test_dma_dst_addr_gen;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        xfer_step = 1'b0;
  logic        blk_end = 1'b0;
  logic [31:0] dst_addr;
  logic        chan_en;
  logic        wrap_flag;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  longint m_addr;
  int     m_dir, m_size, m_area;
  bit     m_blk, m_ie, m_en, m_flag, m_pend;
  longint m_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_dst_addr_gen i_dma_dst_addr_gen (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_step(xfer_step),
    .blk_end(blk_end), .dst_addr(dst_addr), .chan_en(chan_en),
    .wrap_flag(wrap_flag), .irq(irq)
  );

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic longint view(int sel);
    case (sel)
      0: return m_addr;
      1: return longint'(m_dir) | (longint'(m_size) << 2) | (longint'(m_blk) << 4)
                | (longint'(m_en) << 8) | (longint'(m_flag) << 9);
      2: return longint'(m_area) | (longint'(m_ie) << 7);
      default: return 0;
    endcase
  endfunction

  task automatic model_update();
    longint span, base, off, nxt;
    int stepb;
    bit on, wrapped, fire, arm, stop, awr, mwr;
    if (rst) begin
      m_addr = 0; m_dir = 0; m_size = 0; m_area = 0; m_blk = 0; m_ie = 0;
      m_en = 0; m_flag = 0; m_pend = 0; m_rdata = 0;
      return;
    end
    m_rdata = view(int'(reg_sel));
    awr = reg_wr_en && reg_sel == 0;
    mwr = reg_wr_en && reg_sel == 1;
    fire = xfer_step && m_en && !awr;
    stepb = (m_size == 0) ? 1 : (m_size == 1) ? 2 : 4;
    on = (m_area >= 1) && (m_area <= 26);
    span = on ? (longint'(1) << (m_area + 1)) : 64'h1_0000_0000;
    base = m_addr - (m_addr % span);
    off = m_addr % span;
    wrapped = 0;
    if (m_dir == 1) begin
      if (off + stepb >= span) begin wrapped = on; off = on ? 0 : off + stepb - span; end
      else off = off + stepb;
    end else if (m_dir == 2) begin
      if (off < stepb) begin wrapped = on; off = on ? span - 1 : off + span - stepb; end
      else off = off - stepb;
    end
    nxt = base + off;
    arm = fire && wrapped && m_ie;
    stop = (arm && (!m_blk || blk_end)) || (blk_end && m_pend);
    if (blk_end) m_pend = 0; else if (arm && m_blk) m_pend = 1;
    if (stop) m_en = 0; else if (mwr) m_en = reg_wdata[8];
    if (stop) m_flag = 1; else if (mwr && !reg_wdata[9]) m_flag = 0;
    if (awr) m_addr = reg_wdata; else if (fire) m_addr = nxt;
    if (mwr) begin m_dir = reg_wdata[1:0]; m_size = reg_wdata[3:2]; m_blk = reg_wdata[4]; end
    if (reg_wr_en && reg_sel == 2) begin m_ie = reg_wdata[7]; m_area = reg_wdata[4:0]; end
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk("MODEL addr", dst_addr, m_addr);
    chk("MODEL en", chan_en, m_en);
    chk("MODEL flag", wrap_flag, m_flag);
    chk("MODEL irq", irq, m_flag & m_ie);
    chk("MODEL rdata", reg_rdata, m_rdata);
  endtask

  task automatic wr(int sel, logic [31:0] d);
    reg_wr_en = 1; reg_sel = sel[1:0]; reg_wdata = d;
    tick();
    reg_wr_en = 0;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) begin
      xfer_step = 1; tick(); xfer_step = 0;
    end
  endtask

  task automatic rd(int sel, output logic [31:0] v);
    reg_sel = sel[1:0]; tick(); v = reg_rdata;
  endtask

  initial begin
    logic [31:0] v;
    @(negedge clk);
    rst = 1; tick(); tick(); rst = 0;
    // R1 reset state
    chk("R1 addr", dst_addr, 0); chk("R1 en", chan_en, 0);
    chk("R1 flag", wrap_flag, 0); chk("R1 irq", irq, 0); chk("R1 rdata", reg_rdata, 0);

    // R2 plain stepping, then ignored while disabled
    wr(0, 32'h1000_0010); wr(1, 32'h109); steps(3);
    chk("R2 up by 4", dst_addr, 32'h1000_001C);
    wr(1, 32'h009); steps(2);
    chk("R2 disabled holds", dst_addr, 32'h1000_001C);
    wr(1, 32'h109);
    reg_wr_en = 1; reg_sel = 0; reg_wdata = 32'h55; xfer_step = 1; tick();
    reg_wr_en = 0; xfer_step = 0;
    chk("R2 write beats step", dst_addr, 32'h55);

    // R12 wrap with interrupt disabled
    wr(2, 32'h02); wr(0, 32'h1234_5674); steps(1);
    chk("R12 folded", dst_addr, 32'h1234_5670); chk("R12 en kept", chan_en, 1);
    chk("R12 no flag", wrap_flag, 0);
    steps(1);

    // R6 direct stop
    wr(2, 32'h82); steps(1);
    chk("R6 addr", dst_addr, 32'h1234_5670); chk("R6 en cleared", chan_en, 0);
    chk("R6 flag set", wrap_flag, 1); chk("R9 irq", irq, 1);
    steps(1); chk("R2 stopped holds", dst_addr, 32'h1234_5670);
    // R8 resume without reload, flag kept by writing bit9=1
    wr(1, 32'h309); steps(1);
    chk("R8 resume", dst_addr, 32'h1234_5674); chk("R9 flag kept", wrap_flag, 1);
    steps(1);
    wr(2, 32'h02);
    chk("R9 irq masked", irq, 0); chk("R9 flag still", wrap_flag, 1);
    wr(1, 32'h109); chk("R9 flag cleared", wrap_flag, 0);

    // R4 down borrow lands on last byte, R3 high bits fixed
    wr(2, 32'h01); wr(0, 32'h0000_0A00); wr(1, 32'h102); steps(1);
    chk("R4 down fold", dst_addr, 32'h0000_0A03);
    steps(1); chk("R3 in window", dst_addr, 32'h0000_0A02);

    // R7 block deferral
    wr(2, 32'h81); wr(0, 32'h0000_0A00); wr(1, 32'h112); steps(1);
    chk("R7 wrap pending en", chan_en, 1); chk("R7 no flag yet", wrap_flag, 0);
    steps(1); chk("R7 keeps going", dst_addr, 32'h0000_0A02);
    blk_end = 1; tick(); blk_end = 0;
    chk("R7 stop at block end", chan_en, 0); chk("R7 flag", wrap_flag, 1);
    steps(1); chk("R7 halted", dst_addr, 32'h0000_0A02);
    wr(1, 32'h312); steps(1); chk("R8 resume block", dst_addr, 32'h0000_0A01);
    blk_end = 1; tick(); blk_end = 0;
    chk("R7 no pending left", chan_en, 1);

    // R5 no window: full-width roll, enable has no effect
    wr(2, 32'h9B); wr(1, 32'h105); wr(0, 32'hFFFF_FFFE); steps(1);
    chk("R5 roll up", dst_addr, 0); chk("R5 en kept", chan_en, 1); chk("R5 no flag", wrap_flag, 0);
    wr(2, 32'h80); wr(1, 32'h102); wr(0, 32'h0); steps(1);
    chk("R5 roll down", dst_addr, 32'hFFFF_FFFF); chk("R5 no flag 0", wrap_flag, 0);

    // R3 largest window keeps top bits
    wr(2, 32'h1A); wr(1, 32'h109); wr(0, 32'hAFFF_FFFC); steps(1);
    chk("R3 large window", dst_addr, 32'hA800_0000);
    wr(0, 32'hABFF_FFFC); steps(1);
    chk("R3 inner carry", dst_addr, 32'hAC00_0000);

    // R7 wrap coincident with block end
    wr(2, 32'h81); wr(1, 32'h112); wr(0, 32'h0000_0A00);
    xfer_step = 1; blk_end = 1; tick(); xfer_step = 0; blk_end = 0;
    chk("R7 same cycle addr", dst_addr, 32'h0000_0A03);
    chk("R7 same cycle stop", chan_en, 0); chk("R7 same cycle flag", wrap_flag, 1);

    // R10 reserved bits, R11 registered reads
    wr(2, 32'hFF);
    rd(2, v); chk("R10 reserved zero", v, 32'h9F);
    rd(1, v); chk("R11 mode view", v, 32'h212);
    rd(0, v); chk("R11 addr view", v, 32'h0000_0A03);
    rd(3, v); chk("R11 unused select", v, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule